// File: doc/BRIEF.md
# Bidirectional Semaphore Interrupt Unit

This block carries two independent sets of semaphore flags between a host processor and a DSP. The host writes a flag register whose contents go straight to the DSP. A second register collects flags that the DSP raises toward the host. The DSP raises these flags through a per-bit set strobe, and they stay set until the host clears them with a write-one-to-clear access.

The host can mask each incoming flag with a per-bit disable. Any incoming flag that is raised and unmasked drives a single level-sensitive interrupt line. The same condition appears as a summary bit in a read-only status word. The host reaches every register through a synchronous write port and a combinational read port.

Register map (word addresses on `host_addr`): 0 = outgoing flags (read/write), 1 = mask (read/write, 1 = disabled), 2 = clear (write-only, reads as 0), 3 = incoming flags (read-only), 4 = status (read-only). Addresses 5 to 7 are unused and read as 0.

Top module: `sem_irq_unit`

## Requirements
- R1: After reset, the outgoing flags, incoming flags and mask are all zero, `irq` is low, and every address reads 0.
- R2: A host write to address 0 replaces the outgoing flags from the next clock edge. The new value appears on `dsp_rdata` and at address 0.
- R3: Each bit set in `dsp_set` at a clock edge is raised in the incoming flags from that edge onward. It stays raised until the host clears it, and address 3 returns the incoming flags.
- R4: A host write to address 1 loads the mask, which reads back at address 1.
- R5: `irq` is high exactly when at least one incoming flag is 1 and its mask bit is 0. A mask bit of 1 keeps its flag from causing the interrupt.
- R6: A host write to address 2 clears each incoming flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Address 2 always reads 0.
- R7: When `dsp_set` and a host clear target the same bit in the same cycle, the bit ends up set.
- R8: Address 4 returns a status word whose bit 9 equals `irq` and whose other bits are 0.
- R9: Host writes to addresses 3 to 7 change no flag and no mask bit.
- R10: The two directions are separate. `dsp_set` and clears never change the outgoing flags, and writes to address 0 never change the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register word address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| dsp_set | input | 16 | DSP per-bit raise strobe for incoming flags |
| dsp_rdata | output | 16 | Outgoing flags as seen by the DSP |
| irq | output | 1 | Semaphore interrupt, level |

## Verification
Every state change lands at the first clock edge after its strobe. `dsp_rdata`, `irq` and the status word therefore show the result one cycle after the stimulus. Reads are combinational, so they are due as soon as the address settles. The bench applies each stimulus, advances the model at the same edge, and compares `irq` and `dsp_rdata` at the following falling edge on every cycle. Register reads are checked at a falling edge a moment after the address is driven.

// File: rtl/sem_irq_unit.sv
module sem_irq_unit #(
  parameter int FLAGS   = 16,
  parameter int AW      = 3,
  parameter int IRQ_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_wr,
  input  logic [FLAGS-1:0] host_wdata,
  output logic [FLAGS-1:0] host_rdata,
  input  logic [FLAGS-1:0] dsp_set,
  output logic [FLAGS-1:0] dsp_rdata,
  output logic             irq
);
  localparam logic [AW-1:0] A_OUT  = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);
  localparam logic [AW-1:0] A_IN   = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);

  logic [FLAGS-1:0] out_q, in_q, mask_q, clr_bits, status;

  assign clr_bits  = (host_wr && host_addr == A_CLR) ? host_wdata : '0;
  assign dsp_rdata = out_q;
  assign irq       = |(in_q & ~mask_q);

  always_comb begin
    status = '0;
    status[IRQ_BIT] = irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      in_q   <= '0;
      mask_q <= '0;
    end else begin
      if (host_wr && host_addr == A_OUT)  out_q  <= host_wdata;
      if (host_wr && host_addr == A_MASK) mask_q <= host_wdata;
      in_q <= (in_q & ~clr_bits) | dsp_set;
    end
  end

  always_comb begin
    case (host_addr)
      A_OUT:   host_rdata = out_q;
      A_MASK:  host_rdata = mask_q;
      A_IN:    host_rdata = in_q;
      A_STAT:  host_rdata = status;
      default: host_rdata = '0;
    endcase
  end
endmodule

module sem_irq_unit_chk #(
  parameter int FLAGS = 16,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    host_addr,
  input logic             host_wr,
  input logic [FLAGS-1:0] host_wdata,
  input logic [FLAGS-1:0] dsp_set,
  input logic [FLAGS-1:0] dsp_rdata,
  input logic [FLAGS-1:0] in_flags,
  input logic [FLAGS-1:0] mask_flags,
  input logic             irq
);
  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_set != '0) |=> ((in_flags & $past(dsp_set)) == $past(dsp_set)));

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == AW'(2)) |=> ((in_flags & $past(host_wdata & ~dsp_set)) == '0));

  assert_full_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flags == '1) |-> !irq);

  assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == AW'(0)) |=> (dsp_rdata == $past(host_wdata)));

  assert_out_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == AW'(0)) |=> $stable(dsp_rdata));
endmodule

bind sem_irq_unit sem_irq_unit_chk #(.FLAGS(FLAGS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .dsp_set(dsp_set), .dsp_rdata(dsp_rdata),
  .in_flags(in_q), .mask_flags(mask_q), .irq(irq)
);

// File: tb/tb_sem_irq_unit.sv
`timescale 1ns/1ps
module tb_sem_irq_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  host_addr = 0;
  logic        host_wr = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic [15:0] dsp_set = 0;
  logic [15:0] dsp_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic [15:0] m_out = 0, m_in = 0, m_mask = 0;

  always #2.5 clk = ~clk;

  sem_irq_unit dut (.*);

  function automatic logic m_irq();
    return |(m_in & ~m_mask);
  endfunction

  function automatic logic [15:0] m_read(input int a);
    case (a)
      0: return m_out;
      1: return m_mask;
      3: return m_in;
      4: return {6'b0, m_irq(), 9'b0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int a, input logic wr, input logic [15:0] wd, input logic [15:0] st);
    host_addr = 3'(a); host_wr = wr; host_wdata = wd; dsp_set = st;
    @(posedge clk);
    if (rst_n) begin
      if (wr && a == 0) m_out = wd;
      if (wr && a == 1) m_mask = wd;
      m_in = (m_in & ~((wr && a == 2) ? wd : 16'h0)) | st;
    end
    @(negedge clk);
    host_wr = 0; dsp_set = 0;
    check("R5 irq", {15'b0, irq}, {15'b0, m_irq()});
    check("R2/R10 dsp_rdata", dsp_rdata, m_out);
  endtask

  task automatic rd(input int a, input string req);
    host_addr = 3'(a);
    #0.5;
    check(req, host_rdata, m_read(a));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 dsp_rdata", dsp_rdata, 16'h0);
    for (int a = 0; a < 8; a++) rd(a, "R1 read");

    cyc(0, 1, 16'hA5A5, 0);   rd(0, "R2 out");
    cyc(0, 1, 16'h0F0F, 0);   rd(0, "R2 out");
    cyc(0, 0, 0, 16'h0003);   rd(3, "R3 in"); rd(4, "R8 status");
    cyc(0, 0, 0, 0);          rd(3, "R3 hold");
    cyc(1, 1, 16'h0003, 0);   rd(1, "R4 mask"); rd(4, "R8 status masked");
    cyc(1, 1, 16'h0001, 0);   rd(4, "R5 status unmasked");
    cyc(2, 1, 16'h0002, 0);   rd(3, "R6 clear one"); rd(2, "R6 reads 0");
    cyc(2, 1, 16'h0000, 0);   rd(3, "R6 zero no effect");
    cyc(2, 1, 16'h0010, 16'h0010); rd(3, "R7 set wins");
    for (int a = 3; a < 8; a++) begin
      cyc(a, 1, 16'hFFFF, 0);
      rd(0, "R9 out"); rd(1, "R9 mask"); rd(3, "R9 in");
    end
    cyc(0, 0, 0, 16'h8000);   rd(0, "R10 out untouched by set");
    cyc(0, 1, 16'h1234, 0);   rd(3, "R10 in untouched by out write");
    cyc(2, 1, 16'hFFFF, 0);   rd(3, "R10 clear"); rd(0, "R10 out untouched by clear");
    cyc(1, 1, 16'h0000, 0);
    cyc(0, 0, 0, 16'h4000);   rd(4, "R8 status bit9");
    cyc(1, 1, 16'hFFFF, 0);   rd(4, "R5 all masked");
    cyc(2, 1, 16'hFFFF, 16'hFFFF); rd(3, "R7 all set wins");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule